// File: doc/BRIEF.md
# Multiprocessor Serial Frame Transmitter

This block is an asynchronous serial transmitter for the master on a shared multi-drop line. Each frame it sends carries one extra bit after the data bits. That bit tells every receiver whether the frame holds a station address (bit = 1) or a payload byte (bit = 0). A typical exchange sends an address frame first, for example 0x01 with the bit set. Payload frames follow it, for example 0xAA with the bit clear.

Software or a host writes a byte together with its address/data flag into a one-deep holding register. The holding register hands its contents to a shift register, which drives the line. While the shift register is busy, the next byte can already be written, so consecutive frames leave with no idle time between them. The block has two level outputs for interrupt use. One reports that the holding register is empty. The other reports that the line has finished all activity. The bit rate comes from a programmable divider of the system clock, followed by a fixed 16-tick oversampling count per bit.

Top module: `mpUartTx`

## Requirements
- R1: After reset, txLine is high, txEmpty is 1, txEnd is 1 and wrOverflow is 0. Whenever txEnd is 1, txLine is high.
- R2: A frame on txLine has 11 bits, in this order: one low start bit, the 8 bits of wrData least significant bit first, the multiprocessor bit, and one high stop bit.
- R3: The multiprocessor bit equals the wrMpb value captured with the data. The value 1 marks an address frame and 0 marks a data frame.
- R4: Every bit lasts exactly 16*(baudDiv+1) clock cycles, so one frame lasts 176*(baudDiv+1) cycles. With baudDiv = 1 the bit rate is the clock rate divided by 32.
- R5: A write is accepted when wrEn is high in a cycle where txEmpty is 1. txEmpty is 0 in the cycle after an accepted write. When the line is idle, txEmpty returns to 1 one cycle later, when the byte moves into the shift register.
- R6: A byte accepted while a frame is on the line starts its start bit in the cycle right after the current stop bit ends. Consecutive frame starts are exactly one frame length apart.
- R7: txEnd is 1 only when no frame is being shifted and the holding register is empty. After the final stop bit, it rises in the first cycle after that bit's last cycle.
- R8: A write in a cycle where txEmpty is 0 is dropped, and its data never appears on txLine. Such a write sets wrOverflow, which stays at 1 until reset.
- R9: When a write is accepted while txEnd is 1, txLine goes low on the second clock edge after the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| baudDiv | input | DIV_W | Baud tick period minus one, in clock cycles; change only while txEnd is 1 |
| wrEn | input | 1 | Write strobe for the holding register |
| wrData | input | DATA_W | Byte to send |
| wrMpb | input | 1 | Multiprocessor bit for this byte: 1 address, 0 data |
| txLine | output | 1 | Serial output, idles high |
| txEmpty | output | 1 | Holding register empty (interrupt level) |
| txEnd | output | 1 | Transmission fully ended (interrupt level) |
| wrOverflow | output | 1 | Sticky flag: a write was dropped |

## Verification
The hardest situation to reach from the ports is a write that collides with a full holding register. There are two cases: the write lands in the very cycle the holding register hands off to an idle shifter, or it lands during a frame that already has a successor queued. The bench reaches the first case by holding wrEn high for two consecutive cycles with different data. It reaches the second by writing twice in a row as soon as the holding register frees up during a frame. The scoreboard then shows that only the expected bytes ever appear on the line. The bench checks exact back-to-back spacing by recording the cycle of each start bit and comparing the difference with the frame length, at three divider settings.

// File: rtl/mpTxPkg.sv
package mpTxPkg;
  typedef struct packed {
    logic loadShift;  // holding register moves into the shift register
    logic shiftNext;  // advance the line to the next frame bit
    logic baudSync;   // restart the baud tick phase
  } txStrobeT;
endpackage

// File: rtl/mpTxBaud.sv
module mpTxBaud #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [DIV_W-1:0] baudDiv,
  input  logic             sync,
  output logic             tick
);
  logic [DIV_W-1:0] divCnt;

  assign tick = (divCnt == baudDiv);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      divCnt <= '0;
    end else if (sync || tick) begin
      divCnt <= '0;
    end else begin
      divCnt <= divCnt + 1'b1;
    end
  end
endmodule

// File: rtl/mpTxCtrl.sv
module mpTxCtrl
  import mpTxPkg::*;
#(
  parameter int OVS        = 16,
  parameter int FRAME_BITS = 11
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     tick,
  input  logic     holdFull,
  output txStrobeT strobe,
  output logic     busy
);
  localparam int SUB_W = $clog2(OVS);
  localparam int BIT_W = $clog2(FRAME_BITS);
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(OVS - 1);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(FRAME_BITS - 1);

  logic [SUB_W-1:0] subCnt;
  logic [BIT_W-1:0] bitCnt;
  logic bitDone, lastBit, frameDone;

  always_comb begin
    bitDone   = busy && tick && (subCnt == SUB_LAST);
    lastBit   = (bitCnt == BIT_LAST);
    frameDone = bitDone && lastBit;
    strobe.loadShift = holdFull && (!busy || frameDone);
    strobe.shiftNext = bitDone && !lastBit;
    strobe.baudSync  = strobe.loadShift;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy   <= 1'b0;
      subCnt <= '0;
      bitCnt <= '0;
    end else if (strobe.loadShift) begin
      busy   <= 1'b1;
      subCnt <= '0;
      bitCnt <= '0;
    end else if (frameDone) begin
      busy   <= 1'b0;
      subCnt <= '0;
      bitCnt <= '0;
    end else if (busy && tick) begin
      if (subCnt == SUB_LAST) begin
        subCnt <= '0;
        bitCnt <= bitCnt + 1'b1;
      end else begin
        subCnt <= subCnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/mpTxData.sv
module mpTxData
  import mpTxPkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              wrMpb,
  input  txStrobeT          strobe,
  output logic              holdFull,
  output logic              txLine,
  output logic              wrOverflow
);
  localparam int FRAME_BITS = DATA_W + 3;

  logic [DATA_W:0]       holdReg;   // {mpb, data}
  logic [FRAME_BITS-1:0] shiftReg;
  logic [FRAME_BITS-1:0] nextFrame;
  logic accept;

  assign accept    = wrEn && !holdFull;
  assign nextFrame = {1'b1, holdReg, 1'b0};
  assign txLine    = shiftReg[0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdReg    <= '0;
      holdFull   <= 1'b0;
      wrOverflow <= 1'b0;
    end else begin
      if (accept) begin
        holdReg  <= {wrMpb, wrData};
        holdFull <= 1'b1;
      end else if (strobe.loadShift) begin
        holdFull <= 1'b0;
      end
      if (wrEn && holdFull) begin
        wrOverflow <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '1;
    end else if (strobe.loadShift) begin
      shiftReg <= nextFrame;
    end else if (strobe.shiftNext) begin
      shiftReg <= {1'b1, shiftReg[FRAME_BITS-1:1]};
    end
  end
endmodule

// File: rtl/mpUartTx.sv
module mpUartTx
  import mpTxPkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DIV_W-1:0]  baudDiv,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              wrMpb,
  output logic              txLine,
  output logic              txEmpty,
  output logic              txEnd,
  output logic              wrOverflow
);
  localparam int FRAME_BITS = DATA_W + 3;

  txStrobeT strobe;
  logic tick, holdFull, busy;

  mpTxBaud #(.DIV_W(DIV_W)) uBaud (
    .clk(clk), .rstN(rstN), .baudDiv(baudDiv),
    .sync(strobe.baudSync), .tick(tick)
  );

  mpTxCtrl #(.OVS(OVS), .FRAME_BITS(FRAME_BITS)) uCtrl (
    .clk(clk), .rstN(rstN), .tick(tick), .holdFull(holdFull),
    .strobe(strobe), .busy(busy)
  );

  mpTxData #(.DATA_W(DATA_W)) uData (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .wrMpb(wrMpb),
    .strobe(strobe), .holdFull(holdFull), .txLine(txLine),
    .wrOverflow(wrOverflow)
  );

  assign txEmpty = !holdFull;
  assign txEnd   = !busy && !holdFull;
endmodule

// File: rtl/mpUartTxChk.sv
module mpUartTxChk (
  input logic clk,
  input logic rstN,
  input logic wrEn,
  input logic txLine,
  input logic txEmpty,
  input logic txEnd,
  input logic wrOverflow
);
  a_r1_idle_high: assert property (@(posedge clk) disable iff (!rstN)
    txEnd |-> txLine);

  a_r7_end_needs_empty: assert property (@(posedge clk) disable iff (!rstN)
    txEnd |-> txEmpty);

  a_r5_full_after_write: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && txEmpty) |=> !txEmpty);

  a_r8_overflow_set: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !txEmpty) |=> wrOverflow);

  a_r8_overflow_sticky: assert property (@(posedge clk) disable iff (!rstN)
    wrOverflow |=> wrOverflow);

  a_r9_start_from_idle: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && txEnd) |=> ##1 !txLine);
endmodule

bind mpUartTx mpUartTxChk uChk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .txLine(txLine),
  .txEmpty(txEmpty), .txEnd(txEnd), .wrOverflow(wrOverflow)
);

// File: tb/mpUartTx_test.sv
module mpUartTx_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0] baudDiv = 8'd1;
  logic wrEn = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic wrMpb = 1'b0;
  logic txLine, txEmpty, txEnd, wrOverflow;

  mpUartTx uut (
    .clk(clk), .rstN(rstN), .baudDiv(baudDiv), .wrEn(wrEn),
    .wrData(wrData), .wrMpb(wrMpb), .txLine(txLine), .txEmpty(txEmpty),
    .txEnd(txEnd), .wrOverflow(wrOverflow)
  );

  always #5 clk = ~clk;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int bitClk = 32;
  int framesSeen = 0;
  int lastStart = 0;
  int prevStart = 0;
  logic [8:0] expQ[$];

  always @(posedge clk) cyc++;

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic send(logic [7:0] d, logic m);
    @(negedge clk);
    while (!txEmpty) @(negedge clk);
    wrEn = 1'b1; wrData = d; wrMpb = m;
    expQ.push_back({m, d});
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic waitIdle();
    @(negedge clk);
    while (!(txEnd && expQ.size() == 0)) @(negedge clk);
  endtask

  // monitor: decode frames mid-bit and compare with the scoreboard queue
  initial begin
    logic [7:0] gotD;
    logic gotM;
    logic [8:0] want;
    wait (rstN);
    forever begin
      @(negedge clk);
      if (txLine == 1'b0) begin
        prevStart = lastStart;
        lastStart = cyc;
        repeat (bitClk / 2) @(negedge clk);
        check("R2", "start bit", int'(txLine), 0);
        for (int i = 0; i < 8; i++) begin
          repeat (bitClk) @(negedge clk);
          gotD[i] = txLine;
        end
        repeat (bitClk) @(negedge clk);
        gotM = txLine;
        repeat (bitClk) @(negedge clk);
        check("R2", "stop bit", int'(txLine), 1);
        framesSeen++;
        if (expQ.size() == 0) begin
          check("R8", "unexpected frame", int'({gotM, gotD}), 0);
        end else begin
          want = expQ.pop_front();
          check("R2", "data byte", int'(gotD), int'(want[7:0]));
          check("R3", "multiprocessor bit", int'(gotM), int'(want[8]));
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL R2 watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int f;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", "reset txLine", int'(txLine), 1);
    check("R1", "reset txEmpty", int'(txEmpty), 1);
    check("R1", "reset txEnd", int'(txEnd), 1);
    check("R1", "reset wrOverflow", int'(wrOverflow), 0);

    // address frame from idle: exact timing of R5, R9, R7, R4
    @(negedge clk);
    wrEn = 1'b1; wrData = 8'h01; wrMpb = 1'b1;
    expQ.push_back({1'b1, 8'h01});
    @(negedge clk);
    wrEn = 1'b0;
    check("R5", "txEmpty after write", int'(txEmpty), 0);
    check("R9", "line still idle", int'(txLine), 1);
    check("R7", "txEnd after write", int'(txEnd), 0);
    @(negedge clk);
    check("R5", "txEmpty after load", int'(txEmpty), 1);
    check("R9", "start bit begins", int'(txLine), 0);
    repeat (351) @(negedge clk);
    check("R7", "txEnd before stop ends", int'(txEnd), 0);
    @(negedge clk);
    check("R4", "txEnd at frame end", int'(txEnd), 1);
    waitIdle();

    // data frames
    send(8'hAA, 1'b0);
    send(8'h55, 1'b0);
    waitIdle();

    // back-to-back
    send(8'h02, 1'b1);
    send(8'hC3, 1'b0);
    waitIdle();
    check("R6", "start spacing", lastStart - prevStart, 352);

    // overflow: write held into the handoff cycle
    @(negedge clk);
    wrEn = 1'b1; wrData = 8'h3C; wrMpb = 1'b0;
    expQ.push_back({1'b0, 8'h3C});
    @(negedge clk);
    wrData = 8'hE7; wrMpb = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
    check("R8", "overflow flag set", int'(wrOverflow), 1);
    // overflow: write while a successor is already queued
    send(8'h11, 1'b0);
    wrEn = 1'b1; wrData = 8'h99; wrMpb = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
    waitIdle();
    f = framesSeen;
    repeat (800) @(negedge clk);
    check("R8", "no dropped byte sent", framesSeen, f);
    check("R8", "overflow sticky", int'(wrOverflow), 1);

    // other divider settings
    baudDiv = 8'd0; bitClk = 16;
    send(8'hF0, 1'b1);
    send(8'h0F, 1'b0);
    waitIdle();
    check("R4", "spacing div 0", lastStart - prevStart, 176);
    baudDiv = 8'd3; bitClk = 64;
    send(8'h81, 1'b0);
    send(8'h7E, 1'b1);
    waitIdle();
    check("R4", "spacing div 3", lastStart - prevStart, 704);
    check("R1", "idle line at end", int'(txLine), 1);
    check("R2", "scoreboard drained", expQ.size(), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule